// File: doc/BRIEF.md
# Dual Timer/Counter with Four Count Modes

This block holds two independent 8+8-bit timer/counters for a small microcontroller subsystem. Each timer is visible to software as a low byte and a high byte through a simple register write port and a combinational read port. A shared mode register chooses, per timer, one of four count arrangements and whether the timer counts internal machine-cycle ticks (one per twelve clocks) or falling edges on its own external input pin. A shared control register holds the two run bits and the two overflow flags that are offered to interrupt logic.

Timer 0 can be split into two free-standing 8-bit timers; in that arrangement its upper half borrows timer 1's run bit and overflow flag, while timer 1 keeps counting machine ticks without a flag so that its overflows can still pace a serial port. Timer 1 overflows are always brought out as a one-cycle pulse for baud-rate generation.

Top module: `tmr_pair`

## Requirements
- R1: After reset every readable register (addresses 0 to 5) reads 0x00, both flags are low and `baud_tick` is low.
- R2: Address map: 0 control, 1 mode, 2 timer-0 low, 3 timer-0 high, 4 timer-1 low, 5 timer-1 high. Control bits: 0 run0, 1 run1, 4 flag0, 5 flag1. Mode bits: [1:0] timer-0 mode, 2 timer-0 counter select, [5:4] timer-1 mode, 6 timer-1 counter select; other mode bits read 0. Byte registers read back what was written.
- R3: A timer in tick mode advances exactly once per twelve clocks while its run bit is set and holds while it is clear.
- R4: Mode 0 (13-bit): low bits [4:0] count, a carry out of bit 4 increments the high byte, low bits [7:5] hold, and the wrap from 0xFF/0x1F sets the flag.
- R5: Mode 1 (16-bit): {high,low} counts up, and the wrap from 0xFFFF sets the flag.
- R6: Mode 2 (reload): the low byte counts; on the step from 0xFF it is loaded from the high byte and the flag is set.
- R7: Mode 3 on timer 0: the low half counts under run0 and sets flag0; the high half counts machine ticks under run1 and sets flag1; meanwhile timer 1 counts machine ticks whatever run1 is, and never sets flag1.
- R8: Mode 3 on timer 1 freezes timer 1.
- R9: With counter select set, a timer advances once for each falling edge of its pin (`ext_cnt0`/`ext_cnt1`) while running, and ignores machine ticks.
- R10: A flag is set by its timer's overflow, cleared by its acknowledge input or by writing 1 to its control bit; writing 0 to a flag bit leaves it unchanged.
- R11: `baud_tick` pulses high for one cycle, one clock after each timer-1 overflow; in mode 2 with reload value R the pulses are 12*(256-R) clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ext_cnt0 | input | 1 | External count pin, timer 0 |
| ext_cnt1 | input | 1 | External count pin, timer 1 |
| irq_ack0 | input | 1 | Interrupt acknowledge, clears flag 0 |
| irq_ack1 | input | 1 | Interrupt acknowledge, clears flag 1 |
| irq_flag0 | output | 1 | Overflow flag of timer 0 |
| irq_flag1 | output | 1 | Overflow flag of timer 1 (or timer-0 upper half in split) |
| baud_tick | output | 1 | One-cycle pulse per timer-1 overflow |

## Verification
The assertions take for granted that a byte write in the same cycle as an increment wins over the count and that the counter pins are ordinary levels that must rise before they can fall again, so the baud pulse can never stay high two cycles. The stimulus writes registers only while the timer under test is stopped, opens run windows an exact multiple of twelve clocks long so the tick count is known whatever the prescaler phase, and holds every pin level for four clocks so the synchroniser sees each edge.

// File: rtl/tmr_pkg.sv
// Shared types and register addresses for the dual timer/counter.
package tmr_pkg;
    typedef enum logic [1:0] {
        TM_13     = 2'd0,
        TM_16     = 2'd1,
        TM_RELOAD = 2'd2,
        TM_SPLIT  = 2'd3
    } tmr_mode_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_T0_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_T0_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_T1_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_T1_HI = 3'd5;
endpackage

// File: rtl/tmr_prescale.sv
// Machine-cycle prescaler: emits one tick every DIV clocks.
// Assumes DIV >= 2. Counter starts at zero after reset.
module tmr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = $clog2(DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Free-running modulo-DIV count.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tmr_edge_sync.sv
// Two-stage synchroniser plus falling-edge detector for an external count pin.
// Assumes the pin idles high; all stages reset to 1 so no false edge appears.
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchroniser and keep the last settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/tmr_unit.sv
// One timer: low and high byte registers plus the four count arrangements.
// Assumes inc_lo/inc_hi are single-cycle enables. A write to either byte in
// the same cycle as a whole-timer step takes priority and suppresses the step.
// SPLIT_OK selects whether mode 3 splits the timer (1) or freezes it (0).
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int W        = 8,
    parameter int LOW_BITS = 5,
    parameter bit SPLIT_OK = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmr_mode_e    mode,
    input  logic         inc_lo,
    input  logic         inc_hi,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_q,
    output logic         ovf_lo,
    output logic         ovf_hi
);
    logic [W-1:0] lo_n, hi_n;
    logic         any_wr;

    assign any_wr = wr_lo | wr_hi;

    // Next-state and overflow decode for the selected arrangement.
    always_comb begin
        lo_n   = lo_q;
        hi_n   = hi_q;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        unique case (mode)
            TM_13: begin
                if (inc_lo && !any_wr) begin
                    if (&lo_q[LOW_BITS-1:0]) begin
                        lo_n[LOW_BITS-1:0] = '0;
                        hi_n               = hi_q + 1'b1;
                        ovf_lo             = &hi_q;
                    end else begin
                        lo_n[LOW_BITS-1:0] = lo_q[LOW_BITS-1:0] + 1'b1;
                    end
                end
            end
            TM_16: begin
                if (inc_lo && !any_wr) begin
                    {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
                    ovf_lo       = &{hi_q, lo_q};
                end
            end
            TM_RELOAD: begin
                if (inc_lo && !any_wr) begin
                    if (&lo_q) begin
                        lo_n   = hi_q;
                        ovf_lo = 1'b1;
                    end else begin
                        lo_n = lo_q + 1'b1;
                    end
                end
            end
            TM_SPLIT: begin
                if (SPLIT_OK) begin
                    if (inc_lo && !wr_lo) begin
                        lo_n   = lo_q + 1'b1;
                        ovf_lo = &lo_q;
                    end
                    if (inc_hi && !wr_hi) begin
                        hi_n   = hi_q + 1'b1;
                        ovf_hi = &hi_q;
                    end
                end
            end
            default: ;
        endcase
        if (wr_lo) lo_n = wr_data;
        if (wr_hi) hi_n = wr_data;
    end

    // Byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end
endmodule

// File: rtl/tmr_pair.sv
// Dual timer/counter top: register file, clock sources, flags and baud pulse.
// Assumes W >= 8 so the fixed control/mode bit layout fits the data bus.
// Timer 0 may be split (mode 3); then its upper half owns run1/flag1 and
// timer 1 counts ungated without touching flag1.
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int W        = 8,
    parameter int PRESCALE = 12,
    parameter int LOW_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic              ext_cnt0,
    input  logic              ext_cnt1,
    input  logic              irq_ack0,
    input  logic              irq_ack1,
    output logic              irq_flag0,
    output logic              irq_flag1,
    output logic              baud_tick
);
    localparam int NUM_TMR = 2;

    logic              tick;
    logic [NUM_TMR-1:0] pins, fall, src, run_q, flag_q, csel_q, ack;
    logic [NUM_TMR-1:0] inc_lo, inc_hi, ovf_lo, ovf_hi, set_flag;
    logic [NUM_TMR-1:0] wr_lo, wr_hi;
    tmr_mode_e          mode_q [NUM_TMR];
    logic [W-1:0]       cnt_lo [NUM_TMR];
    logic [W-1:0]       cnt_hi [NUM_TMR];
    logic               split, wr_ctrl, wr_mode, baud_q;

    assign pins = {ext_cnt1, ext_cnt0};
    assign ack  = {irq_ack1, irq_ack0};

    tmr_prescale #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    // Write decode for control, mode and the four byte registers.
    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign wr_mode  = wr_en && (wr_addr == A_MODE);
    assign wr_lo[0] = wr_en && (wr_addr == A_T0_LO);
    assign wr_hi[0] = wr_en && (wr_addr == A_T0_HI);
    assign wr_lo[1] = wr_en && (wr_addr == A_T1_LO);
    assign wr_hi[1] = wr_en && (wr_addr == A_T1_HI);

    assign split = (mode_q[0] == TM_SPLIT);

    // Count enables: each timer's source, gated by its run bit or the split rules.
    assign inc_lo[0] = run_q[0] & src[0];
    assign inc_hi[0] = split & run_q[1] & tick;
    assign inc_lo[1] = split ? src[1] : (run_q[1] & src[1]);
    assign inc_hi[1] = 1'b0;

    // Flag set sources: flag1 follows timer-0 upper half while split.
    assign set_flag[0] = ovf_lo[0];
    assign set_flag[1] = split ? ovf_hi[0] : (ovf_lo[1] | ovf_hi[1]);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        tmr_edge_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[i]),
            .fall (fall[i])
        );

        assign src[i] = csel_q[i] ? fall[i] : tick;

        tmr_unit #(
            .W       (W),
            .LOW_BITS(LOW_BITS),
            .SPLIT_OK(i == 0)
        ) u_unit (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (mode_q[i]),
            .inc_lo (inc_lo[i]),
            .inc_hi (inc_hi[i]),
            .wr_lo  (wr_lo[i]),
            .wr_hi  (wr_hi[i]),
            .wr_data(wr_data),
            .lo_q   (cnt_lo[i]),
            .hi_q   (cnt_hi[i]),
            .ovf_lo (ovf_lo[i]),
            .ovf_hi (ovf_hi[i])
        );

        // Overflow flag: hardware set wins, then acknowledge or write-one clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  flag_q[i] <= 1'b0;
            else if (set_flag[i])                        flag_q[i] <= 1'b1;
            else if (ack[i] || (wr_ctrl && wr_data[4+i])) flag_q[i] <= 1'b0;
        end
    end

    // Run bits, mode fields and counter selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= '0;
            csel_q    <= '0;
            mode_q[0] <= TM_13;
            mode_q[1] <= TM_13;
        end else begin
            if (wr_ctrl) run_q <= wr_data[1:0];
            if (wr_mode) begin
                mode_q[0] <= tmr_mode_e'(wr_data[1:0]);
                mode_q[1] <= tmr_mode_e'(wr_data[5:4]);
                csel_q    <= {wr_data[6], wr_data[2]};
            end
        end
    end

    // Baud pulse, one clock after each timer-1 overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) baud_q <= 1'b0;
        else        baud_q <= ovf_lo[1];
    end

    // Register read mux.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:  begin
                rd_data[1:0] = run_q;
                rd_data[5:4] = flag_q;
            end
            A_MODE:  begin
                rd_data[1:0] = mode_q[0];
                rd_data[2]   = csel_q[0];
                rd_data[5:4] = mode_q[1];
                rd_data[6]   = csel_q[1];
            end
            A_T0_LO: rd_data = cnt_lo[0];
            A_T0_HI: rd_data = cnt_hi[0];
            A_T1_LO: rd_data = cnt_lo[1];
            A_T1_HI: rd_data = cnt_hi[1];
            default: rd_data = '0;
        endcase
    end

    assign irq_flag0 = flag_q[0];
    assign irq_flag1 = flag_q[1];
    assign baud_tick = baud_q;
endmodule

// File: rtl/tmr_pair_chk.sv
// Property checker for tmr_pair, attached by bind below.
module tmr_pair_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              irq_ack0,
    input logic              irq_ack1,
    input logic              irq_flag0,
    input logic              irq_flag1,
    input logic              baud_tick,
    input logic [1:0]        run_q,
    input logic [1:0]        mode0,
    input logic [1:0]        mode1,
    input logic [7:0]        t0_lo,
    input logic [7:0]        t0_hi,
    input logic [7:0]        t1_lo,
    input logic [7:0]        t1_hi
);
    // R3: both run bits clear and no write -> timer 0 holds.
    a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_q) == 2'b00 && !$past(wr_en)) |-> ({t0_hi, t0_lo} == $past({t0_hi, t0_lo})));

    // R6: timer 0 in reload mode leaving 0xFF takes the old high byte.
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode0) == 2'd2 && !$past(wr_en) && $past(t0_lo) == 8'hFF && t0_lo != 8'hFF)
        |-> (t0_lo == $past(t0_hi)));

    // R8: timer 1 in mode 3 is frozen.
    a_r8_t1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode1) == 2'd3 && !$past(wr_en)) |-> ({t1_hi, t1_lo} == $past({t1_hi, t1_lo})));

    // R10: a flag only falls after its acknowledge or a write-one clear.
    a_r10_flag0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag0) |-> $past(irq_ack0 || (wr_en && wr_addr == A_CTRL && wr_data[4])));
    a_r10_flag1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag1) |-> $past(irq_ack1 || (wr_en && wr_addr == A_CTRL && wr_data[5])));

    // R11: the baud pulse lasts one cycle.
    a_r11_baud_single: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);
endmodule

bind tmr_pair tmr_pair_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq_ack0 (irq_ack0),
    .irq_ack1 (irq_ack1),
    .irq_flag0(irq_flag0),
    .irq_flag1(irq_flag1),
    .baud_tick(baud_tick),
    .run_q    (run_q),
    .mode0    (mode_q[0]),
    .mode1    (mode_q[1]),
    .t0_lo    (cnt_lo[0]),
    .t0_hi    (cnt_hi[0]),
    .t1_lo    (cnt_lo[1]),
    .t1_hi    (cnt_hi[1])
);

// File: tb/tmr_pair_tb.sv
`timescale 1ns/1ps
module tmr_pair_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_cnt0 = 1'b1, ext_cnt1 = 1'b1;
    logic       irq_ack0 = 1'b0, irq_ack1 = 1'b0;
    logic       irq_flag0, irq_flag1, baud_tick;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc = 0;
    int pulses = 0;
    int last_pulse = -1;
    int gap = 0;

    tmr_pair u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_cnt0(ext_cnt0), .ext_cnt1(ext_cnt1),
        .irq_ack0(irq_ack0), .irq_ack1(irq_ack1), .irq_flag0(irq_flag0),
        .irq_flag1(irq_flag1), .baud_tick(baud_tick)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Baud pulse monitor (R11).
    always @(negedge clk) begin
        if (rst_n && baud_tick) begin
            if (last_pulse >= 0) gap = cyc - last_pulse;
            last_pulse = cyc;
            pulses++;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // Open a run window exactly 12*n clocks long: n machine ticks.
    task automatic run_ticks(input logic [1:0] mask, input int n);
        wr(3'd0, {6'd0, mask});
        repeat (12 * n - 2) @(negedge clk);
        wr(3'd0, 8'h00);
    endtask

    task automatic pulse_pin(input int idx);
        if (idx == 0) ext_cnt0 = 1'b0; else ext_cnt1 = 1'b0;
        repeat (4) @(negedge clk);
        if (idx == 0) ext_cnt0 = 1'b1; else ext_cnt1 = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // One increment of a timer per the mode rules: returns {ovf, hi, lo}.
    function automatic logic [16:0] step(input int md, input logic [7:0] lo, input logic [7:0] hi);
        logic ovf = 1'b0;
        if (md == 0) begin
            if (lo[4:0] == 5'h1F) begin
                lo[4:0] = 5'h00; ovf = (hi == 8'hFF); hi = hi + 8'd1;
            end else lo[4:0] = lo[4:0] + 5'd1;
        end else if (md == 1) begin
            ovf = ({hi, lo} == 16'hFFFF);
            {hi, lo} = {hi, lo} + 16'd1;
        end else begin
            if (lo == 8'hFF) begin lo = hi; ovf = 1'b1; end
            else lo = lo + 8'd1;
        end
        return {ovf, hi, lo};
    endfunction

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        void'($urandom(32'h51ED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reg", {8'd0, v}, 16'h0000);
        end
        chk("R1 outputs", {13'd0, irq_flag0, irq_flag1, baud_tick}, 16'h0000);

        // R2: readback and mode field layout.
        wr(3'd2, 8'hA5); wr(3'd3, 8'h5A); wr(3'd4, 8'h3C); wr(3'd5, 8'hC3);
        rd(3'd2, v); chk("R2 t0 lo", {8'd0, v}, 16'h00A5);
        rd(3'd3, v); chk("R2 t0 hi", {8'd0, v}, 16'h005A);
        rd(3'd4, v); chk("R2 t1 lo", {8'd0, v}, 16'h003C);
        rd(3'd5, v); chk("R2 t1 hi", {8'd0, v}, 16'h00C3);
        wr(3'd1, 8'hFF);
        rd(3'd1, v); chk("R2 mode", {8'd0, v}, 16'h0077);
        wr(3'd1, 8'h00);

        // R3/R5: timer 0 mode 1, exact step count, then holds when stopped.
        wr(3'd1, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        run_ticks(2'b01, 5);
        rd(3'd2, v); chk("R3 five ticks", {8'd0, v}, 16'h0005);
        repeat (60) @(negedge clk);
        rd(3'd2, v); chk("R3 stopped hold", {8'd0, v}, 16'h0005);

        // R4/R5/R6 random: mode model checked per timer.
        for (int it = 0; it < 24; it++) begin
            int tm = int'($urandom % 2);
            int md = int'($urandom % 3);
            int n  = 1 + int'($urandom % 24);
            logic [7:0] lo = 8'($urandom);
            logic [7:0] hi = 8'($urandom);
            logic [16:0] r;
            logic any_ovf = 1'b0;
            string tag;
            if ($urandom % 2 == 0) begin lo = lo | 8'hF0; hi = 8'hFF; end
            tag = (md == 0) ? "R4" : (md == 1) ? "R5" : "R6";
            wr(3'd1, tm == 0 ? 8'(md) : 8'(md << 4));
            wr(3'(2 + 2 * tm), lo);
            wr(3'(3 + 2 * tm), hi);
            wr(3'd0, 8'h30);
            r = {1'b0, hi, lo};
            for (int k = 0; k < n; k++) begin
                r = step(md, r[7:0], r[15:8]);
                any_ovf = any_ovf | r[16];
            end
            run_ticks(tm == 0 ? 2'b01 : 2'b10, n);
            rd(3'(2 + 2 * tm), v);
            rd(3'(3 + 2 * tm), v2);
            chk({tag, " count"}, {v2, v}, r[15:0]);
            rd(3'd0, v);
            chk({tag, " flag"}, {15'd0, v[4 + tm]}, {15'd0, any_ovf});
        end

        // R7: split timer 0.
        wr(3'd1, 8'h03); wr(3'd0, 8'h30);
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFD);
        run_ticks(2'b11, 3);
        rd(3'd2, v); rd(3'd3, v2);
        chk("R7 split halves", {v2, v}, 16'h0001);
        chk("R7 split flags", {14'd0, irq_flag0, irq_flag1}, 16'h0003);
        wr(3'd0, 8'h30);
        wr(3'd2, 8'h10); wr(3'd3, 8'h20);
        run_ticks(2'b01, 4);
        rd(3'd2, v); rd(3'd3, v2);
        chk("R7 low only", {v2, v}, 16'h2014);
        // Timer 1 free-runs while split and never sets flag1.
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h1F); wr(3'd5, 8'hFF); wr(3'd0, 8'h30);
        wr(3'd1, 8'h03);
        repeat (30) @(negedge clk);
        wr(3'd1, 8'h00);
        rd(3'd5, v);
        chk("R7 t1 free-run", {8'd0, v}, 16'h0000);
        chk("R7 no flag1", {15'd0, irq_flag1}, 16'h0000);

        // R8: timer 1 mode 3 frozen.
        wr(3'd1, 8'h30); wr(3'd4, 8'h05); wr(3'd5, 8'h06);
        run_ticks(2'b10, 5);
        rd(3'd4, v); rd(3'd5, v2);
        chk("R8 t1 frozen", {v2, v}, 16'h0605);

        // R9: counter mode on timer 1 (mode 1, select bit 6) and timer 0.
        wr(3'd1, 8'h50); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        wr(3'd0, 8'h02);
        repeat (50) @(negedge clk);
        rd(3'd4, v); chk("R9 ticks ignored", {8'd0, v}, 16'h0000);
        for (int p = 0; p < 7; p++) pulse_pin(1);
        repeat (6) @(negedge clk);
        wr(3'd0, 8'h00);
        rd(3'd4, v); chk("R9 t1 edges", {8'd0, v}, 16'h0007);
        wr(3'd1, 8'h05); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd0, 8'h30);
        wr(3'd0, 8'h01);
        for (int p = 0; p < 3; p++) pulse_pin(0);
        repeat (6) @(negedge clk);
        wr(3'd0, 8'h00);
        rd(3'd2, v); rd(3'd3, v2);
        chk("R9 t0 edges", {v2, v}, 16'h0001);
        chk("R9 t0 flag", {15'd0, irq_flag0}, 16'h0001);

        // R10: flag clearing rules.
        wr(3'd0, 8'h00);
        chk("R10 write zero keeps", {15'd0, irq_flag0}, 16'h0001);
        wr(3'd0, 8'h10);
        chk("R10 write one clears", {15'd0, irq_flag0}, 16'h0000);
        wr(3'd1, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        run_ticks(2'b01, 1);
        chk("R10 set again", {15'd0, irq_flag0}, 16'h0001);
        @(negedge clk); irq_ack0 = 1'b1;
        @(negedge clk); irq_ack0 = 1'b0;
        chk("R10 ack0 clears", {15'd0, irq_flag0}, 16'h0000);
        wr(3'd1, 8'h10); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        run_ticks(2'b10, 1);
        chk("R10 flag1 set", {15'd0, irq_flag1}, 16'h0001);
        @(negedge clk); irq_ack1 = 1'b1;
        @(negedge clk); irq_ack1 = 1'b0;
        chk("R10 ack1 clears", {15'd0, irq_flag1}, 16'h0000);

        // R11: baud pulses from timer 1 reload mode, reload 0xFD.
        begin
            int base;
            wr(3'd1, 8'h20); wr(3'd4, 8'hFD); wr(3'd5, 8'hFD);
            repeat (3) @(negedge clk);
            base = pulses;
            run_ticks(2'b10, 30);
            repeat (3) @(negedge clk);
            chk("R11 pulse count", 16'(pulses - base), 16'd10);
            chk("R11 pulse spacing", 16'(gap), 16'd36);
            chk("R11 idle low", {15'd0, baud_tick}, 16'h0000);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule